// File: doc/BRIEF.md
# Condition-Flag Arithmetic and Logic Unit

This block computes one 32-bit data-processing operation per cycle and keeps a four-bit condition-flag register of negative, zero, carry and overflow. Two operands and a 4-bit operation code are presented together with a flag-update enable. The result and its write-enable are produced combinationally in the same cycle. The flag register loads on the next rising clock edge, but only for the operations and enable settings listed below.

The operations are:

- Arithmetic: add, add-with-carry, subtract and subtract-with-carry.
- Logical: AND, OR, XOR and bit-clear.
- Moves: move and move-inverted.
- Flag-only: four forms that set flags from a subtract, an add, an AND or an XOR without asking for a write-back.

The carry-using operations read the carry held in the flag register, so back-to-back instructions chain through it.

All pins are plain control and data pins. An operation is taken every cycle, and there is no handshake or back-pressure.

Top module: `nzcv_alu`

## Requirements
- R1: Code 0 gives op_a + op_b. Code 1 gives op_a + op_b + C, where C is the carry bit currently held in the flag register.
- R2: Code 2 gives op_a - op_b, computed as op_a + ~op_b + 1. Code 3 gives op_a - op_b + C - 1, computed as op_a + ~op_b + C, so a held C of 1 means no extra borrow.
- R3: The logical and move codes give these results:
  - Code 4 gives op_a AND op_b.
  - Code 5 gives op_a OR op_b.
  - Code 6 gives op_a XOR op_b.
  - Code 7 gives op_a AND NOT op_b.
  - Code 8 passes op_b through unchanged.
  - Code 9 gives NOT op_b.
- R4: For the arithmetic codes (0 to 3, 10, 11), the carry flag loads the carry out of bit 31 of the effective addition.
- R5: For the arithmetic codes, the overflow flag loads 1 only when both effective addends have the same sign bit and bit 31 of the sum differs from it.
- R6: flags is {N, Z, C, V} with N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. On any flag update, N loads bit 31 of the computed value and Z loads 1 exactly when all 32 bits of the computed value are zero.
- R7: An update by a logical or move code (4 to 9, 12, 13) leaves C and V at their previous values.
- R8: For the result-producing codes 0 to 9, the flags load only when flag_en is 1. With flag_en at 0, the result and result_we are still produced and the flags hold.
- R9: The flag-only codes behave as follows:
  - Code 10 computes op_a - op_b.
  - Code 11 computes op_a + op_b.
  - Code 12 computes op_a AND op_b.
  - Code 13 computes op_a XOR op_b.
  
  Each of these updates the flags whatever flag_en is, and keeps result_we at 0. The computed value still appears on result.
- R10: result_we is 1 for codes 0 to 9. Codes 14 and 15 give result 0 and result_we 0, and leave the flags unchanged.
- R11: A synchronous active-high rst clears all four flags on the clock edge. Reset takes priority over any update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 4 | Operation code (0 to 13 defined, 14 and 15 reserved) |
| flag_en | input | 1 | Flag-update request for the result-producing codes |
| result | output | 32 | Combinational result of the current operation |
| result_we | output | 1 | Result write-enable, combinational |
| flags | output | 4 | Registered {N, Z, C, V} |

## Verification
result and result_we depend only on the present inputs and the present flags. The bench therefore samples them 1 ns after driving new inputs, inside the same cycle. flags belongs to the operation applied in the cycle before, so it is sampled 1 ns after the following rising edge. New inputs are applied at that same moment, so no operation is ever seen at two edges. In the vector table, each carry-using entry depends on the flag state left by the entry before it, and the expected values are worked out in that order.

// File: rtl/nzcv_alu_pkg.sv
package nzcv_alu_pkg;

  localparam int unsigned OP_W   = 4;
  localparam int unsigned FLAG_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_AND = 4'd4,  OP_ORR = 4'd5,  OP_XOR = 4'd6,  OP_BIC = 4'd7,
    OP_MOV = 4'd8,  OP_MVN = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_TST = 4'd12, OP_TEQ = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_mode_e;

  typedef enum logic [2:0] {
    LG_AND, LG_ORR, LG_XOR, LG_BIC, LG_MOV, LG_MVN
  } logic_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic      legal;
    logic      arith;
    logic      inv_b;
    cin_mode_e cin;
    logic_fn_e lfn;
    logic      flag_only;
  } ctrl_t;

  function automatic ctrl_t decode_op(input logic [OP_W-1:0] code);
    ctrl_t c;
    c = '{legal: 1'b1, arith: 1'b0, inv_b: 1'b0, cin: CIN_ZERO,
          lfn: LG_AND, flag_only: 1'b0};
    case (code)
      OP_ADD: c.arith = 1'b1;
      OP_ADC: begin c.arith = 1'b1; c.cin = CIN_FLAG; end
      OP_SUB: begin c.arith = 1'b1; c.inv_b = 1'b1; c.cin = CIN_ONE; end
      OP_SBC: begin c.arith = 1'b1; c.inv_b = 1'b1; c.cin = CIN_FLAG; end
      OP_AND: c.lfn = LG_AND;
      OP_ORR: c.lfn = LG_ORR;
      OP_XOR: c.lfn = LG_XOR;
      OP_BIC: c.lfn = LG_BIC;
      OP_MOV: c.lfn = LG_MOV;
      OP_MVN: c.lfn = LG_MVN;
      OP_CMP: begin
        c.arith = 1'b1; c.inv_b = 1'b1; c.cin = CIN_ONE; c.flag_only = 1'b1;
      end
      OP_CMN: begin c.arith = 1'b1; c.flag_only = 1'b1; end
      OP_TST: begin c.lfn = LG_AND; c.flag_only = 1'b1; end
      OP_TEQ: begin c.lfn = LG_XOR; c.flag_only = 1'b1; end
      default: c.legal = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = inv_b ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    carry = wide[W];
    ovf   = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import nzcv_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  output logic [W-1:0] y
);
  always_comb begin
    case (fn)
      LG_AND:  y = a & b;
      LG_ORR:  y = a | b;
      LG_XOR:  y = a ^ b;
      LG_BIC:  y = a & ~b;
      LG_MOV:  y = b;
      LG_MVN:  y = ~b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import nzcv_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         upd_cv,
  input  logic [W-1:0] value,
  input  logic         c_new,
  input  logic         v_new,
  output flags_t       flags
);
  localparam int unsigned MSB = W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (upd) begin
      flags.n <= value[MSB];
      flags.z <= (value == '0);
      if (upd_cv) begin
        flags.c <= c_new;
        flags.v <= v_new;
      end
    end
  end

  // R11
  rst_clear_chk: assert property (@(posedge clk) rst |=> flags == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(flags));

  // R6
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> flags.n == $past(value[MSB]));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> flags.z == ($past(value) == '0));

  // R7
  cv_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && !upd_cv) |=> (flags.c == $past(flags.c)) && (flags.v == $past(flags.v)));
endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu
  import nzcv_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [OP_W-1:0]   op_sel,
  input  logic              flag_en,
  output logic [W-1:0]      result,
  output logic              result_we,
  output logic [FLAG_W-1:0] flags
);
  localparam int unsigned MSB = W - 1;

  ctrl_t        ctrl;
  flags_t       flag_q;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_carry;
  logic         add_ovf;
  logic [W-1:0] lg_y;
  logic [W-1:0] value;
  logic         upd;

  always_comb begin
    ctrl = decode_op(op_sel);
    case (ctrl.cin)
      CIN_ONE:  add_cin = 1'b1;
      CIN_FLAG: add_cin = flag_q.c;
      default:  add_cin = 1'b0;
    endcase
  end

  alu_adder #(.W(W)) u_adder (
    .a     (op_a),
    .b     (op_b),
    .inv_b (ctrl.inv_b),
    .cin   (add_cin),
    .sum   (add_sum),
    .carry (add_carry),
    .ovf   (add_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a  (op_a),
    .b  (op_b),
    .fn (ctrl.lfn),
    .y  (lg_y)
  );

  always_comb begin
    value     = ctrl.arith ? add_sum : lg_y;
    result    = ctrl.legal ? value : '0;
    result_we = ctrl.legal && !ctrl.flag_only;
    upd       = ctrl.legal && (ctrl.flag_only || flag_en);
  end

  alu_flag_reg #(.W(W)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .upd    (upd),
    .upd_cv (ctrl.arith),
    .value  (value),
    .c_new  (add_carry),
    .v_new  (add_ovf),
    .flags  (flag_q)
  );

  assign flags = flag_q;

  // R9
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel inside {OP_CMP, OP_CMN, OP_TST, OP_TEQ}) |-> !result_we);

  // R10
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel > OP_TEQ) |-> (result == '0) && !result_we);

  // R5
  ovf_sign_chk: assert property (@(posedge clk) disable iff (rst)
    add_ovf |-> (op_a[MSB] == (ctrl.inv_b ? ~op_b[MSB] : op_b[MSB])));

  // R4
  plain_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADD && add_carry) |-> (add_sum < op_a));
endmodule

// File: tb/test_nzcv_alu.sv
module test_nzcv_alu;
  import nzcv_alu_pkg::*;

  localparam int unsigned W  = 32;
  localparam int unsigned NV = 19;

  typedef struct packed {
    logic [4:0]  req;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        en;
    logic [31:0] r;
    logic        we;
    logic [3:0]  f;
  } vec_t;

  // Each flags value is {N,Z,C,V} after the entry; entries chain through C.
  localparam vec_t VECS [NV] = '{
    '{5'd1,  4'd0,  32'h0000000F, 32'hFFFFFFFF, 1'b1, 32'h0000000E, 1'b1, 4'b0010}, // R1 R4 add
    '{5'd1,  4'd1,  32'h0000000F, 32'hFFFFFFFF, 1'b1, 32'h0000000F, 1'b1, 4'b0010}, // R1 adc C=1
    '{5'd2,  4'd2,  32'h0000000F, 32'hFFFFFFFF, 1'b1, 32'h00000010, 1'b1, 4'b0000}, // R2 sub
    '{5'd2,  4'd3,  32'h0000000F, 32'hFFFFFFFF, 1'b1, 32'h0000000F, 1'b1, 4'b0000}, // R2 sbc C=0
    '{5'd5,  4'd0,  32'h7FFFFFFF, 32'h00000001, 1'b1, 32'h80000000, 1'b1, 4'b1001}, // R5 overflow
    '{5'd8,  4'd0,  32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 4'b1001}, // R8 no update
    '{5'd7,  4'd4,  32'h00000055, 32'h00000061, 1'b1, 32'h00000041, 1'b1, 4'b0001}, // R3 R7 and
    '{5'd3,  4'd5,  32'h00000055, 32'h00000061, 1'b1, 32'h00000075, 1'b1, 4'b0001}, // R3 or
    '{5'd3,  4'd6,  32'h00000055, 32'h00000061, 1'b1, 32'h00000034, 1'b1, 4'b0001}, // R3 xor
    '{5'd3,  4'd7,  32'h00000055, 32'h00000061, 1'b1, 32'h00000014, 1'b1, 4'b0001}, // R3 bic
    '{5'd6,  4'd9,  32'h12345678, 32'h0000000C, 1'b1, 32'hFFFFFFF3, 1'b1, 4'b1001}, // R6 mvn N
    '{5'd6,  4'd8,  32'h12345678, 32'h00000000, 1'b1, 32'h00000000, 1'b1, 4'b0101}, // R6 mov Z
    '{5'd9,  4'd10, 32'h00000011, 32'h00000023, 1'b0, 32'hFFFFFFEE, 1'b0, 4'b1000}, // R9 cmp less
    '{5'd9,  4'd10, 32'h00000023, 32'h00000023, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R9 cmp equal
    '{5'd9,  4'd12, 32'h0000000F, 32'h00000018, 1'b0, 32'h00000008, 1'b0, 4'b0010}, // R9 tst
    '{5'd9,  4'd13, 32'h80000000, 32'h00000000, 1'b0, 32'h80000000, 1'b0, 4'b1010}, // R9 teq
    '{5'd5,  4'd11, 32'h80000000, 32'h80000000, 1'b1, 32'h00000000, 1'b0, 4'b0111}, // R5 cmn
    '{5'd2,  4'd3,  32'h00000005, 32'h00000003, 1'b1, 32'h00000002, 1'b1, 4'b0010}, // R2 sbc C=1
    '{5'd10, 4'd14, 32'h0000FFFF, 32'h0000FFFF, 1'b1, 32'h00000000, 1'b0, 4'b0010}  // R10 reserved
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic [3:0]    op_sel = 4'd0;
  logic          flag_en = 1'b0;
  logic [W-1:0]  result;
  logic          result_we;
  logic [3:0]    flags;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nzcv_alu #(.W(W)) i_nzcv_alu (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .flag_en   (flag_en),
    .result    (result),
    .result_we (result_we),
    .flags     (flags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic en);
    op_sel = op; op_a = a; op_b = b; flag_en = en;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R11 flags after reset", {28'd0, flags}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].en);
      #1;
      check($sformatf("R%0d vector %0d result", VECS[i].req, i), result, VECS[i].r);
      check($sformatf("R10 vector %0d result_we", i), {31'd0, result_we}, {31'd0, VECS[i].we});
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d flags", VECS[i].req, i), {28'd0, flags}, {28'd0, VECS[i].f});
    end

    // R11: reset beats a flag-only update that would set all flags
    rst = 1'b1;
    apply(4'd11, 32'h80000000, 32'h80000000, 1'b1);
    @(posedge clk); #1;
    check("R11 reset over update", {28'd0, flags}, 32'd0);
    rst = 1'b0;

    // R1: carry-in from cleared C
    apply(4'd1, 32'd1, 32'd1, 1'b1);
    #1;
    check("R1 adc after reset", result, 32'd2);
    @(posedge clk); #1;
    check("R1 adc flags", {28'd0, flags}, 32'd0);

    // R9: test form updates flags with enable low
    apply(4'd12, 32'h000000F0, 32'h0000000F, 1'b0);
    @(posedge clk); #1;
    check("R9 tst zero without enable", {28'd0, flags}, 32'b0100);

    // R8: subtract with enable low still gives result, flags hold
    apply(4'd2, 32'd0, 32'd1, 1'b0);
    #1;
    check("R8 sub result", result, 32'hFFFFFFFF);
    @(posedge clk); #1;
    check("R8 flags held", {28'd0, flags}, 32'b0100);

    // R10: reserved 15 with enable high
    apply(4'd15, 32'h1, 32'h1, 1'b1);
    #1;
    check("R10 code 15 result", result, 32'd0);
    @(posedge clk); #1;
    check("R10 code 15 flags", {28'd0, flags}, 32'b0100);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule